// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Generator

This block produces four independent pulse-width-modulated outputs from a shared timebase strobe, usually a one-microsecond tick. Each channel is programmed through three word registers: a period register that also acts as the commit trigger, a duty register, and a control register that holds a power-of-two timebase divider and an output polarity bit. Software writes the duty and control values first. It then writes the period. The channel picks up all four settings together at the end of the period it is running, so an output never shows a mix of old and new settings.

Each channel is a two-state machine. In `CH_IDLE` the output is held low and the counters rest at zero. In `CH_RUN` a counter steps once per divided tick and is compared with the active duty value. The transitions have these names. *start* goes from `CH_IDLE` to `CH_RUN` when a commit with a nonzero period is pending. *drop* stays in `CH_IDLE` and discards a pending commit whose period is zero. *wrap* stays in `CH_RUN` at the end of a period; it reloads the settings when a commit is pending and otherwise only clears the counter. *stop* goes from `CH_RUN` to `CH_IDLE` at the end of a period when the pending commit carries a zero period.

Top module: `shadow_pwm`

## Requirements
- R1: The registers of channel n sit at these byte addresses: period at 0x400+4n, duty at 0x420+4n, control at 0x440+4n. Period and duty are 16 bits wide. In the control register, bits [1:0] hold the divider code and bit 5 holds polarity. A read returns the last value written, with zeros in all bits that are not stored. Any other read address returns zero.
- R2: A write to any other address changes no register and no output. This includes a channel index of 4 or more and a byte address that is not word aligned.
- R3: A divider code k makes the running counter advance once every 2^k timebase strobes.
- R4: While running, the output is at its active level when the counter is below the active duty, and inactive otherwise. A duty of 0 gives a constant inactive level. A duty equal to or greater than the period gives a constant active level.
- R5: With polarity bit 5 set, the active level is low and the inactive level is high.
- R6: Duty and control writes have no effect until the period register is written. After a period write, the new period, duty, divider and polarity all take effect together at the end of the running period. The counter and the divider both restart from zero at that point.
- R7: An idle channel that receives a nonzero period write loads its settings on the next clock edge and starts its first period at counter value zero, without waiting for a boundary.
- R8: A period write of zero lets the running period finish. After that the output stays low, whatever the polarity.
- R9: After reset every channel is idle with a low output, and every register reads zero.
- R10: Each channel runs only from its own registers. Writing one channel never disturbs another.
- R11: If a period write lands on the same clock edge as a period end, the settings staged before that write are committed. The new write stays pending until the next period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_tick | input | 1 | One-cycle timebase strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Each register is updated on the edge that captures the write, so a read at the next falling edge already returns the new value. A commit on an idle channel shows at `pwm_out` one edge later. A commit on a running channel shows on the edge that completes the period, which is the last strobe of the old period. The bench holds a behavioural model that applies these same edge-by-edge rules to integers. It advances the model on each rising edge and compares all four outputs with it on every falling edge, so each result is checked in exactly the cycle it falls due. Read data is checked one unit after a falling edge, once the combinational read path has settled.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs #(
    parameter int NCH  = 4,
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int DIVW = 2,
    parameter int POL_BIT = 5,
    parameter logic [AW-1:0] PER_BASE = 12'h400,
    parameter logic [AW-1:0] DUT_BASE = 12'h420,
    parameter logic [AW-1:0] CTL_BASE = 12'h440
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [DW-1:0]             rd_data,
    output logic [NCH-1:0][CW-1:0]    sh_per,
    output logic [NCH-1:0][CW-1:0]    sh_dut,
    output logic [NCH-1:0][DIVW-1:0]  sh_div,
    output logic [NCH-1:0]            sh_pol,
    output logic [NCH-1:0]            per_wr
);
    function automatic logic [AW-1:0] slot(input logic [AW-1:0] base, input int idx);
        return base + AW'(idx * 4);
    endfunction

    logic [NCH-1:0] dut_wr, ctl_wr;
    logic           unused_wr;
    assign unused_wr = ^wr_data;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign per_wr[g] = wr_en && (wr_addr == slot(PER_BASE, g));
        assign dut_wr[g] = wr_en && (wr_addr == slot(DUT_BASE, g));
        assign ctl_wr[g] = wr_en && (wr_addr == slot(CTL_BASE, g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_per[g] <= '0;
                sh_dut[g] <= '0;
                sh_div[g] <= '0;
                sh_pol[g] <= 1'b0;
            end else begin
                if (per_wr[g]) sh_per[g] <= wr_data[CW-1:0];
                if (dut_wr[g]) sh_dut[g] <= wr_data[CW-1:0];
                if (ctl_wr[g]) begin
                    sh_div[g] <= wr_data[DIVW-1:0];
                    sh_pol[g] <= wr_data[POL_BIT];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == slot(PER_BASE, i)) rd_data = DW'(sh_per[i]);
            if (rd_addr == slot(DUT_BASE, i)) rd_data = DW'(sh_dut[i]);
            if (rd_addr == slot(CTL_BASE, i)) begin
                rd_data[DIVW-1:0] = sh_div[i];
                rd_data[POL_BIT]  = sh_pol[i];
            end
        end
    end

    // R2: a write that hits no register leaves all shadow storage untouched
    assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|{per_wr, dut_wr, ctl_wr})) |=>
        ($stable(sh_per) && $stable(sh_dut) && $stable(sh_div) && $stable(sh_pol)));
endmodule

// File: rtl/shadow_pwm_chan.sv
module shadow_pwm_chan
    import shadow_pwm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int DIVW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            per_wr,
    input  logic [CW-1:0]   sh_per,
    input  logic [CW-1:0]   sh_dut,
    input  logic [DIVW-1:0] sh_div,
    input  logic            sh_pol,
    output logic            pwm
);
    localparam int PW = (1 << DIVW) - 1;

    ch_state_e       state, state_nx;
    logic            pend;
    logic [CW-1:0]   a_per, a_dut, cnt;
    logic [DIVW-1:0] a_div;
    logic            a_pol;
    logic [PW-1:0]   pre, pre_mask;
    logic            dtick, at_end, commit, load, stop;

    assign pre_mask = PW'((1 << a_div) - 1);
    assign dtick    = tick && (pre == pre_mask);
    assign at_end   = (state == CH_RUN) && dtick && (cnt == a_per - CW'(1));
    assign commit   = pend && ((state == CH_IDLE) || at_end);
    assign load     = commit && (sh_per != '0);
    assign stop     = commit && (sh_per == '0) && (state == CH_RUN);

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (load) state_nx = CH_RUN;   // start (drop stays here)
            CH_RUN:  if (stop) state_nx = CH_IDLE;  // stop (wrap stays here)
            default: state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            a_per <= '0;
            a_dut <= '0;
            a_div <= '0;
            a_pol <= 1'b0;
            cnt   <= '0;
            pre   <= '0;
        end else begin
            if (per_wr)      pend <= 1'b1;
            else if (commit) pend <= 1'b0;
            if (load) begin
                a_per <= sh_per;
                a_dut <= sh_dut;
                a_div <= sh_div;
                a_pol <= sh_pol;
                cnt   <= '0;
                pre   <= '0;
            end else if (stop) begin
                cnt <= '0;
                pre <= '0;
            end else if (state == CH_RUN && tick) begin
                if (dtick) begin
                    pre <= '0;
                    cnt <= at_end ? '0 : cnt + CW'(1);
                end else begin
                    pre <= pre + PW'(1);
                end
            end
        end
    end

    always_comb begin
        pwm = 1'b0;
        unique case (state)
            CH_IDLE: pwm = 1'b0;
            CH_RUN:  pwm = (cnt < a_dut) ^ a_pol;
            default: pwm = 1'b0;
        endcase
    end

    // R4: the counter never leaves the running period
    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN) |-> (cnt < a_per));
    // R3: the prescaler never passes the division selected by the divider code
    assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre <= pre_mask);
    // R6: active settings only change at a period end
    assert_settings_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && !at_end) |=>
        ($stable(a_per) && $stable(a_dut) && $stable(a_div) && $stable(a_pol)));
    // R6: a period write always leaves a commit pending
    assert_pend_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> pend);
    // R8: a zero-period commit at a period end returns the channel to idle
    assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && pend && sh_per == '0) |=> (state == CH_IDLE));
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm #(
    parameter int NCH  = 4,
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int DIVW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           time_tick,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0][CW-1:0]   sh_per, sh_dut;
    logic [NCH-1:0][DIVW-1:0] sh_div;
    logic [NCH-1:0]           sh_pol, per_wr;

    shadow_pwm_regs #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .DIVW(DIVW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sh_per(sh_per), .sh_dut(sh_dut), .sh_div(sh_div), .sh_pol(sh_pol),
        .per_wr(per_wr)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        shadow_pwm_chan #(.CW(CW), .DIVW(DIVW)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(time_tick), .per_wr(per_wr[g]),
            .sh_per(sh_per[g]), .sh_dut(sh_dut[g]), .sh_div(sh_div[g]),
            .sh_pol(sh_pol[g]), .pwm(pwm_out[g])
        );
    end
endmodule

// File: tb/tb_shadow_pwm.sv
`timescale 1ns/1ps
module tb_shadow_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        time_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    shadow_pwm dut (
        .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    int tick_gap = 1, tick_cnt = 0;
    string cur_req = "R9";
    bit done = 0;

    // behavioural model state
    int m_sp[4], m_sd[4], m_sdiv[4], m_spol[4], m_pend[4];
    int m_st[4], m_ap[4], m_ad[4], m_adiv[4], m_apol[4], m_cnt[4], m_pre[4];

    function automatic int model_read(input int a);
        for (int c = 0; c < 4; c++) begin
            if (a == 'h400 + 4*c) return m_sp[c];
            if (a == 'h420 + 4*c) return m_sd[c];
            if (a == 'h440 + 4*c) return m_sdiv[c] | (m_spol[c] << 5);
        end
        return 0;
    endfunction

    function automatic int model_out(input int c);
        if (m_st[c] == 0) return 0;
        return ((m_cnt[c] < m_ad[c]) ? 1 : 0) ^ m_apol[c];
    endfunction

    task automatic m_load(input int c);
        m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c]; m_adiv[c] = m_sdiv[c];
        m_apol[c] = m_spol[c]; m_cnt[c] = 0; m_pre[c] = 0; m_st[c] = 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_sp[c] = 0; m_sd[c] = 0; m_sdiv[c] = 0; m_spol[c] = 0; m_pend[c] = 0;
                m_st[c] = 0; m_ap[c] = 0; m_ad[c] = 0; m_adiv[c] = 0; m_apol[c] = 0;
                m_cnt[c] = 0; m_pre[c] = 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                if (m_st[c] == 0) begin
                    if (m_pend[c] != 0) begin
                        m_pend[c] = 0;
                        if (m_sp[c] != 0) m_load(c);
                    end
                end else if (time_tick) begin
                    if (m_pre[c] == (1 << m_adiv[c]) - 1) begin
                        if (m_cnt[c] == m_ap[c] - 1) begin
                            if (m_pend[c] != 0) begin
                                m_pend[c] = 0;
                                if (m_sp[c] == 0) begin
                                    m_st[c] = 0; m_cnt[c] = 0; m_pre[c] = 0;
                                end else m_load(c);
                            end else begin
                                m_cnt[c] = 0; m_pre[c] = 0;
                            end
                        end else begin
                            m_cnt[c] = m_cnt[c] + 1; m_pre[c] = 0;
                        end
                    end else m_pre[c] = m_pre[c] + 1;
                end
            end
            if (wr_en) begin
                for (int c = 0; c < 4; c++) begin
                    if (wr_addr == 12'(32'h400 + 4*c)) begin m_sp[c] = wr_data[15:0]; m_pend[c] = 1; end
                    if (wr_addr == 12'(32'h420 + 4*c)) m_sd[c] = wr_data[15:0];
                    if (wr_addr == 12'(32'h440 + 4*c)) begin m_sdiv[c] = wr_data[1:0]; m_spol[c] = wr_data[5]; end
                end
            end
        end
    end

    // per-cycle output comparison
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < 4; c++) begin
                checks++;
                if (int'(pwm_out[c]) != model_out(c)) begin
                    errors++;
                    $display("FAIL %s ch%0d pwm_out actual %0d expected %0d at cycle %0d",
                             cur_req, c, pwm_out[c], model_out(c), cycles);
                end
            end
        end
    end

    // timebase strobe
    always @(negedge clk) begin
        tick_cnt++;
        if (tick_cnt >= tick_gap) begin time_tick <= 1'b1; tick_cnt = 0; end
        else time_tick <= 1'b0;
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string req);
        @(negedge clk);
        rd_addr = 12'(a);
        #1;
        checks++;
        if (int'(rd_data) != model_read(a)) begin
            errors++;
            $display("FAIL %s read 0x%0h actual 0x%0h expected 0x%0h", req, a, rd_data, model_read(a));
        end
    endtask

    task automatic rd_fixed(input int a, input int exp, input string req);
        @(negedge clk);
        rd_addr = 12'(a);
        #1;
        checks++;
        if (int'(rd_data) != exp) begin
            errors++;
            $display("FAIL %s read 0x%0h actual 0x%0h expected 0x%0h", req, a, rd_data, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #20000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        cur_req = "R9";
        for (int c = 0; c < 4; c++) begin
            rd_fixed('h400 + 4*c, 0, "R9");
            rd_fixed('h420 + 4*c, 0, "R9");
            rd_fixed('h440 + 4*c, 0, "R9");
        end
        // R7 / R4: channel 0 starts from idle
        cur_req = "R7";
        wr('h440, 0); wr('h420, 3); wr('h400, 8);
        run(40);
        // R3: divider 4 on channel 1, strobe every 2 clocks
        cur_req = "R3";
        tick_gap = 2;
        wr('h444, 2); wr('h424, 2); wr('h404, 5);
        run(120);
        // R5: inverted polarity on channel 2
        cur_req = "R5";
        wr('h448, 'h21); wr('h428, 1); wr('h408, 4);
        run(60);
        // R4: duty 0 then duty above period on channel 3
        cur_req = "R4";
        wr('h42C, 0); wr('h40C, 3);
        run(30);
        wr('h42C, 10); wr('h40C, 3);
        run(30);
        // R1: control read masks unstored bits
        cur_req = "R1";
        wr('h44C, 32'hFFFF_FFFF);
        rd_fixed('h44C, 'h23, "R1");
        rd_chk('h42C, "R1");
        rd_fixed('h40C, 3, "R1");
        rd_fixed('h300, 0, "R1");
        wr('h44C, 0);
        // R6: staged duty without a period write changes nothing
        cur_req = "R6";
        tick_gap = 1;
        wr('h420, 6); wr('h440, 1);
        run(50);
        rd_fixed('h420, 6, "R6");
        wr('h400, 9);
        run(80);
        // R10: rewrite channel 1 while others run
        cur_req = "R10";
        wr('h424, 4); wr('h404, 7);
        run(60);
        // R2: unmapped writes
        cur_req = "R2";
        wr('h410, 1); wr('h401, 1); wr('h460, 'h21); wr('h000, 5); wr('h43C, 3);
        run(20);
        for (int c = 0; c < 4; c++) begin
            rd_chk('h400 + 4*c, "R2");
            rd_chk('h420 + 4*c, "R2");
            rd_chk('h440 + 4*c, "R2");
        end
        // R8: zero-period writes stop channels after the current period
        cur_req = "R8";
        wr('h400, 0); wr('h408, 0);
        run(60);
        // R11: random traffic with writes landing on period ends
        cur_req = "R11";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 7));
            if (r == 0) begin
                int c, k;
                c = int'($urandom_range(0, 3));
                k = int'($urandom_range(0, 3));
                if (k == 0) wr('h400 + 4*c, int'($urandom_range(0, 6)));
                else if (k == 1) wr('h420 + 4*c, int'($urandom_range(0, 7)));
                else if (k == 2) wr('h440 + 4*c, int'($urandom));
                else wr('h410 + int'($urandom_range(0, 3)), 2);
            end else begin
                if (r == 1) tick_gap = int'($urandom_range(1, 3));
                @(negedge clk);
            end
        end
        for (int c = 0; c < 4; c++) begin
            rd_chk('h400 + 4*c, "R11");
            rd_chk('h440 + 4*c, "R11");
        end
        run(5);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule